// File: doc/BRIEF.md
# Serial GPIO Expander Controller

This controller multiplies the number of general-purpose pins a chip can offer. It keeps a chain of external shift registers refreshed over four wires: a bit clock, a serial data output, a serial data input and a load strobe. Frames are streamed back to back. Each frame shifts the programmed output values out and, at the same time, shifts in a parallel snapshot taken by the external input registers. A strobe closes every frame. It transfers the shifted outputs to the external latches and takes a fresh input snapshot.

The chain has 32 ports. Every port carries the same number of bits, programmable from 1 to 4, so up to 128 pins are served. A 32-bit enable mask removes ports from the stream altogether, which shortens the frame. Each pin has its own polarity bit, applied on the way out and on the way back in. The bit clock is derived from the reference clock by a programmable divider. A word-addressed register port holds the configuration and the pin values, and returns the captured inputs.

Top module: `serial_gpio_expander`

## Requirements
- R1: After reset the pins `ser_clk`, `ser_load` and `ser_dout` are low, the controller is disabled, the enable mask reads 0xFFFFFFFF, the divider reads the `DIV_RESET` parameter (default 4) and the control word reads 0x30 (4 bits per port).
- R2: Register map, word addressed on `reg_addr`: 0 is control (bit 0 enable, bits 5:4 = bits per port minus one), 1 is the divider (bits 15:0), 2 is the port mask (bit n enables port n), 4..7 are output values and 8..11 are polarity bits (word w holds pins 32w..32w+31), and 12..15 are the shown input values. Written values read back. Writes to 12..15 are ignored.
- R3: A frame carries the enabled ports in ascending order and, within a port, bits 0 up to bits-per-port minus one. Pin p*4+b maps to port p, bit b. Disabled ports take no cycles.
- R4: With L = divider (a divider of 0 acts as 1), each bit lasts 2L reference cycles. `ser_clk` is low for the first L cycles and high for the next L. `ser_dout` changes only as a bit starts, which is the falling edge.
- R5: After the last bit, `ser_load` is high for 2L cycles while `ser_clk` and `ser_dout` stay low. The next frame starts in the cycle after `ser_load` falls.
- R6: `ser_din` is sampled as `ser_clk` rises and stored at the pin of the bit being shifted. The shown input words change only as the strobe begins, and then hold the whole frame. Pins not in that frame show 0 before polarity.
- R7: Polarity bit 1 inverts a pin. `ser_dout` carries output XOR polarity, and the input words read captured XOR polarity.
- R8: With the enable bit clear, `ser_clk` and `ser_load` are low from the next cycle on, and a running frame is abandoned. With an all-zero mask, no new frame starts.
- R9: Writes to divider, mask or bits per port during a frame leave that frame unchanged and apply from the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on address |
| ser_clk | output | 1 | Bit clock to the shift chain |
| ser_load | output | 1 | Load strobe to the shift chain |
| ser_dout | output | 1 | Serial data to the output registers |
| ser_din | input | 1 | Serial data from the input registers |

## Verification
A register write takes effect at its clock edge. The sequencer reacts one edge later: a frame begins in the cycle after it sees the enable, and the pins fall one cycle after the enable is cleared. Within a frame, cycle k belongs to bit k/(2L) and is in its high half when k mod 2L is at least L. The shown inputs change at the edge that raises the strobe. The bench locks onto the cycle after a strobe falls, which is cycle 0 of a frame. From there it predicts all three outputs for every cycle of the frame and its strobe, and drives `ser_din` for the bit of the current cycle. It reads the input words only after the strobe has begun.

// File: rtl/sgx_pkg.sv
// Shared definitions for the serial GPIO expander.
// Assumes: register addresses are word addresses; the output, polarity and input
// banks follow the mask register at a fixed base.
package sgx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_LOAD
    } sgx_state_e;

    localparam int ADDR_CTRL    = 0;
    localparam int ADDR_DIV     = 1;
    localparam int ADDR_MASK    = 2;
    localparam int ADDR_BANK0   = 4;
    localparam int CTRL_BPP_LSB = 4;
endpackage

// File: rtl/sgx_regs.sv
// Register bank: control, divider, port mask, output values and polarity bits.
// It also presents the captured inputs with polarity applied.
// Assumes: NUM_PORTS <= DATA_W, DIV_W <= DATA_W, NUM_GPIO a multiple of DATA_W.
module sgx_regs
    import sgx_pkg::*;
#(
    parameter int NUM_PORTS = 32,
    parameter int BITS_MAX  = 4,
    parameter int DIV_W     = 16,
    parameter int DIV_RESET = 4,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           reg_we,
    input  logic [ADDR_W-1:0]              reg_addr,
    input  logic [DATA_W-1:0]              reg_wdata,
    output logic [DATA_W-1:0]              reg_rdata,
    output logic                           enable,
    output logic [$clog2(BITS_MAX)-1:0]    bpp_m1,
    output logic [DIV_W-1:0]               div,
    output logic [NUM_PORTS-1:0]           mask,
    output logic [NUM_PORTS*BITS_MAX-1:0]  out_bits,
    output logic [NUM_PORTS*BITS_MAX-1:0]  pol_bits,
    input  logic [NUM_PORTS*BITS_MAX-1:0]  cap_bits
);
    localparam int NUM_GPIO = NUM_PORTS * BITS_MAX;
    localparam int BIT_W    = $clog2(BITS_MAX);
    localparam int NWORD    = NUM_GPIO / DATA_W;
    localparam int A_OUT    = ADDR_BANK0;
    localparam int A_POL    = A_OUT + NWORD;
    localparam int A_IN     = A_POL + NWORD;

    logic [NUM_GPIO-1:0] in_shown;

    // Apply polarity to the captured inputs for software.
    assign in_shown = cap_bits ^ pol_bits;

    // Hold the configuration and pin values; writes to the input bank are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable   <= 1'b0;
            bpp_m1   <= '1;
            div      <= DIV_W'(DIV_RESET);
            mask     <= '1;
            out_bits <= '0;
            pol_bits <= '0;
        end else if (reg_we) begin
            if (reg_addr == ADDR_W'(ADDR_CTRL)) begin
                enable <= reg_wdata[0];
                bpp_m1 <= reg_wdata[CTRL_BPP_LSB +: BIT_W];
            end
            if (reg_addr == ADDR_W'(ADDR_DIV))
                div <= reg_wdata[DIV_W-1:0];
            if (reg_addr == ADDR_W'(ADDR_MASK))
                mask <= reg_wdata[NUM_PORTS-1:0];
            for (int w = 0; w < NWORD; w++) begin
                if (reg_addr == ADDR_W'(A_OUT + w))
                    out_bits[w*DATA_W +: DATA_W] <= reg_wdata;
                if (reg_addr == ADDR_W'(A_POL + w))
                    pol_bits[w*DATA_W +: DATA_W] <= reg_wdata;
            end
        end
    end

    // Decode the read address into the read data word.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(ADDR_CTRL)) begin
            reg_rdata[0]                    = enable;
            reg_rdata[CTRL_BPP_LSB +: BIT_W] = bpp_m1;
        end
        if (reg_addr == ADDR_W'(ADDR_DIV))
            reg_rdata[DIV_W-1:0] = div;
        if (reg_addr == ADDR_W'(ADDR_MASK))
            reg_rdata[NUM_PORTS-1:0] = mask;
        for (int w = 0; w < NWORD; w++) begin
            if (reg_addr == ADDR_W'(A_OUT + w))
                reg_rdata = out_bits[w*DATA_W +: DATA_W];
            if (reg_addr == ADDR_W'(A_POL + w))
                reg_rdata = pol_bits[w*DATA_W +: DATA_W];
            if (reg_addr == ADDR_W'(A_IN + w))
                reg_rdata = in_shown[w*DATA_W +: DATA_W];
        end
    end

    // R1: configuration leaves reset with every port enabled and the default divider
    a_r1_reset_values: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (mask == '1 && !enable && div == DIV_W'(DIV_RESET)));
endmodule

// File: rtl/sgx_half_timer.sv
// Half-bit timer: counts reference cycles and pulses tick in the last cycle of
// every half bit period of len cycles.
// Assumes: len >= 1 and changes only in a cycle where the count wraps or is held.
module sgx_half_timer #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] len,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic             at_end;

    // Flag the last cycle of the current half period.
    assign at_end = (cnt == len - DIV_W'(1));
    assign tick   = run && at_end;

    // Count cycles inside a half period; hold at zero while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            cnt <= '0;
        else if (at_end)
            cnt <= '0;
        else
            cnt <= cnt + DIV_W'(1);
    end

    // R4: the count never passes the half-period length
    a_r4_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt < len));
endmodule

// File: rtl/sgx_port_pick.sv
// Port finder: returns the lowest enabled port whose number is at least start.
// Assumes: start may equal NUM_PORTS, which yields found = 0.
module sgx_port_pick #(
    parameter int NUM_PORTS = 32
) (
    input  logic [NUM_PORTS-1:0]         mask,
    input  logic [$clog2(NUM_PORTS):0]   start,
    output logic [$clog2(NUM_PORTS)-1:0] idx,
    output logic                         found
);
    localparam int PORT_W = $clog2(NUM_PORTS);

    // Scan downward so that the lowest qualifying port is the one kept.
    always_comb begin
        idx   = '0;
        found = 1'b0;
        for (int i = NUM_PORTS - 1; i >= 0; i--) begin
            if (mask[i] && (i >= int'(start))) begin
                idx   = PORT_W'(i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sgx_seq.sv
// Frame sequencer: walks the enabled ports and bits and drives the bit clock,
// data and load strobe. It samples serial input and publishes it at frame end.
// Assumes: BITS_MAX is a power of two, so pin index = {port, bit}; tick comes
// from a half-bit timer that runs whenever run is high.
module sgx_seq
    import sgx_pkg::*;
#(
    parameter int NUM_PORTS = 32,
    parameter int BITS_MAX  = 4,
    parameter int DIV_W     = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           enable,
    input  logic [NUM_PORTS-1:0]           cfg_mask,
    input  logic [DIV_W-1:0]               cfg_div,
    input  logic [$clog2(BITS_MAX)-1:0]    cfg_bpp_m1,
    input  logic [NUM_PORTS*BITS_MAX-1:0]  out_drive,
    input  logic                           ser_din,
    input  logic                           tick,
    input  logic [$clog2(NUM_PORTS)-1:0]   first_idx,
    input  logic                           first_ok,
    input  logic [$clog2(NUM_PORTS)-1:0]   next_idx,
    input  logic                           next_ok,
    output logic                           run,
    output logic [DIV_W-1:0]               half_len,
    output logic [NUM_PORTS-1:0]           lat_mask,
    output logic [$clog2(NUM_PORTS)-1:0]   cur_port,
    output logic                           ser_clk,
    output logic                           ser_load,
    output logic                           ser_dout,
    output logic [NUM_PORTS*BITS_MAX-1:0]  in_vis
);
    localparam int NUM_GPIO = NUM_PORTS * BITS_MAX;
    localparam int BIT_W    = $clog2(BITS_MAX);

    sgx_state_e          state;
    logic [BIT_W-1:0]    bit_idx;
    logic [BIT_W-1:0]    bit_nxt;
    logic [BIT_W-1:0]    lat_bpp_m1;
    logic                load_half;
    logic [NUM_GPIO-1:0] cap_buf;
    logic [DIV_W-1:0]    eff_div;
    logic                go;
    logic                frame_start;

    // Decide whether a frame may start and what the effective divider is.
    assign go          = enable && first_ok;
    assign eff_div     = (cfg_div == '0) ? DIV_W'(1) : cfg_div;
    assign bit_nxt     = bit_idx + BIT_W'(1);
    assign run         = (state != ST_IDLE);
    assign frame_start = go && ((state == ST_IDLE) ||
                                (state == ST_LOAD && tick && load_half));

    // Step through low half, high half and strobe; latch the config at frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            ser_clk    <= 1'b0;
            ser_load   <= 1'b0;
            ser_dout   <= 1'b0;
            cur_port   <= '0;
            bit_idx    <= '0;
            lat_bpp_m1 <= '0;
            lat_mask   <= '0;
            half_len   <= DIV_W'(1);
            load_half  <= 1'b0;
            cap_buf    <= '0;
            in_vis     <= '0;
        end else if (!enable) begin
            state     <= ST_IDLE;
            ser_clk   <= 1'b0;
            ser_load  <= 1'b0;
            ser_dout  <= 1'b0;
            load_half <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                end
                ST_LOW: begin
                    if (tick) begin
                        state                      <= ST_HIGH;
                        ser_clk                    <= 1'b1;
                        cap_buf[{cur_port, bit_idx}] <= ser_din;
                    end
                end
                ST_HIGH: begin
                    if (tick) begin
                        ser_clk <= 1'b0;
                        if (bit_idx != lat_bpp_m1) begin
                            bit_idx  <= bit_nxt;
                            state    <= ST_LOW;
                            ser_dout <= out_drive[{cur_port, bit_nxt}];
                        end else if (next_ok) begin
                            cur_port <= next_idx;
                            bit_idx  <= '0;
                            state    <= ST_LOW;
                            ser_dout <= out_drive[{next_idx, BIT_W'(0)}];
                        end else begin
                            state     <= ST_LOAD;
                            ser_load  <= 1'b1;
                            ser_dout  <= 1'b0;
                            load_half <= 1'b0;
                            in_vis    <= cap_buf;
                        end
                    end
                end
                ST_LOAD: begin
                    if (tick) begin
                        if (!load_half) begin
                            load_half <= 1'b1;
                        end else begin
                            ser_load  <= 1'b0;
                            load_half <= 1'b0;
                            state     <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
            if (frame_start) begin
                state      <= ST_LOW;
                ser_clk    <= 1'b0;
                ser_load   <= 1'b0;
                cur_port   <= first_idx;
                bit_idx    <= '0;
                ser_dout   <= out_drive[{first_idx, BIT_W'(0)}];
                lat_mask   <= cfg_mask;
                lat_bpp_m1 <= cfg_bpp_m1;
                half_len   <= eff_div;
                cap_buf    <= '0;
                load_half  <= 1'b0;
            end
        end
    end

    // R5: the bit clock rests low for the whole strobe
    a_r5_load_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
        ser_load |-> !ser_clk);

    // R8: clearing enable silences the clock and strobe one cycle later
    a_r8_off_pins_low: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!ser_clk && !ser_load));

    // R4: data is frozen while the bit clock stays high
    a_r4_data_held_high: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk && $past(ser_clk)) |-> $stable(ser_dout));

    // R6: shown inputs move only as the strobe starts
    a_r6_input_at_load: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vis != $past(in_vis)) |-> $rose(ser_load));

    // R9: frame shape stays fixed inside a frame
    a_r9_shape_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HIGH) |-> ($stable(half_len) && $stable(lat_mask)));
endmodule

// File: rtl/serial_gpio_expander.sv
// Serial GPIO expander top: register bank, half-bit timer, two port finders
// (first port of a frame from the live mask, next port from the frame's mask)
// and the frame sequencer.
// Assumes: BITS_MAX is a power of two; NUM_PORTS and DIV_W fit in DATA_W.
module serial_gpio_expander #(
    parameter int NUM_PORTS = 32,
    parameter int BITS_MAX  = 4,
    parameter int DIV_W     = 16,
    parameter int DIV_RESET = 4,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              ser_clk,
    output logic              ser_load,
    output logic              ser_dout,
    input  logic              ser_din
);
    localparam int NUM_GPIO = NUM_PORTS * BITS_MAX;
    localparam int PORT_W   = $clog2(NUM_PORTS);
    localparam int BIT_W    = $clog2(BITS_MAX);

    logic                 enable;
    logic [BIT_W-1:0]     bpp_m1;
    logic [DIV_W-1:0]     div;
    logic [NUM_PORTS-1:0] mask;
    logic [NUM_GPIO-1:0]  out_bits;
    logic [NUM_GPIO-1:0]  pol_bits;
    logic [NUM_GPIO-1:0]  out_drive;
    logic [NUM_GPIO-1:0]  in_vis;
    logic                 run;
    logic                 tick;
    logic [DIV_W-1:0]     half_len;
    logic [NUM_PORTS-1:0] lat_mask;
    logic [PORT_W-1:0]    cur_port;
    logic [PORT_W:0]      nxt_start;
    logic [PORT_W-1:0]    first_idx;
    logic                 first_ok;
    logic [PORT_W-1:0]    next_idx;
    logic                 next_ok;

    // Drive the pins with polarity applied; search upward from the next port.
    assign out_drive = out_bits ^ pol_bits;
    assign nxt_start = {1'b0, cur_port} + (PORT_W + 1)'(1);

    sgx_regs #(
        .NUM_PORTS(NUM_PORTS), .BITS_MAX(BITS_MAX), .DIV_W(DIV_W),
        .DIV_RESET(DIV_RESET), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .enable(enable),
        .bpp_m1(bpp_m1), .div(div), .mask(mask), .out_bits(out_bits),
        .pol_bits(pol_bits), .cap_bits(in_vis)
    );

    sgx_half_timer #(.DIV_W(DIV_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(run), .len(half_len), .tick(tick)
    );

    sgx_port_pick #(.NUM_PORTS(NUM_PORTS)) u_pick_first (
        .mask(mask), .start('0), .idx(first_idx), .found(first_ok)
    );

    sgx_port_pick #(.NUM_PORTS(NUM_PORTS)) u_pick_next (
        .mask(lat_mask), .start(nxt_start), .idx(next_idx), .found(next_ok)
    );

    sgx_seq #(.NUM_PORTS(NUM_PORTS), .BITS_MAX(BITS_MAX), .DIV_W(DIV_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_mask(mask),
        .cfg_div(div), .cfg_bpp_m1(bpp_m1), .out_drive(out_drive),
        .ser_din(ser_din), .tick(tick), .first_idx(first_idx),
        .first_ok(first_ok), .next_idx(next_idx), .next_ok(next_ok),
        .run(run), .half_len(half_len), .lat_mask(lat_mask),
        .cur_port(cur_port), .ser_clk(ser_clk), .ser_load(ser_load),
        .ser_dout(ser_dout), .in_vis(in_vis)
    );
endmodule

// File: tb/tb_serial_gpio_expander.sv
module tb_serial_gpio_expander;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 32;
    localparam int BM = 4;
    localparam int NG = NP * BM;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    wire  [31:0] reg_rdata;
    wire         ser_clk;
    wire         ser_load;
    wire         ser_dout;
    logic        ser_din = 1'b0;

    int errors = 0;
    int checks = 0;
    bit out_v [NG];
    bit pol_v [NG];
    bit feed  [NG];
    bit used  [NG];
    logic [31:0] m_mask;
    int m_bpp;
    int m_len;

    serial_gpio_expander dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ser_clk(ser_clk),
        .ser_load(ser_load), .ser_dout(ser_dout), .ser_din(ser_din)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = 4'(a);
        #1 d = reg_rdata;
    endtask

    function automatic logic [31:0] pack(input int w, input bit sel_pol);
        logic [31:0] v;
        for (int i = 0; i < 32; i++) v[i] = sel_pol ? pol_v[w*32+i] : out_v[w*32+i];
        return v;
    endfunction

    task automatic load_pins();
        for (int w = 0; w < 4; w++) begin
            wr(4 + w, pack(w, 1'b0));
            wr(8 + w, pack(w, 1'b1));
        end
    endtask

    // Reconfigure while disabled, then enable and sit at cycle 0 of the second frame.
    task automatic start(input logic [31:0] mask, input int bpp, input int dv);
        wr(0, 32'h0);
        wr(1, 32'(dv));
        wr(2, mask);
        wr(0, (32'(bpp - 1) << 4) | 32'h1);
        m_mask = mask; m_bpp = bpp; m_len = (dv == 0) ? 1 : dv;
        sync_frame();
    endtask

    task automatic sync_frame();
        @(negedge clk);
        while (ser_load !== 1'b1) @(negedge clk);
        while (ser_load === 1'b1) @(negedge clk);
    endtask

    // Reference model: one frame plus strobe, predicted and compared every cycle.
    task automatic run_frame(input string req, input int chg_k, input int ca,
                             input logic [31:0] cd);
        int order[$];
        int nb, total;
        for (int g = 0; g < NG; g++) used[g] = 1'b0;
        for (int p = 0; p < NP; p++)
            if (m_mask[p])
                for (int b = 0; b < m_bpp; b++) order.push_back(p * BM + b);
        nb = order.size();
        total = (nb + 1) * 2 * m_len;
        for (int k = 0; k < total; k++) begin
            int slot, ph;
            logic [2:0] exp_v, act_v;
            if (k > 0) @(negedge clk);
            slot = k / (2 * m_len);
            ph = k % (2 * m_len);
            if (k == chg_k) begin
                reg_we = 1'b1; reg_addr = 4'(ca); reg_wdata = cd;
            end else begin
                reg_we = 1'b0;
            end
            if (slot < nb) begin
                ser_din = feed[order[slot]];
                used[order[slot]] = 1'b1;
                exp_v = {1'(ph >= m_len), 1'b0, 1'(out_v[order[slot]] ^ pol_v[order[slot]])};
            end else begin
                ser_din = 1'b0;
                exp_v = 3'b010;
            end
            act_v = {ser_clk, ser_load, ser_dout};
            chk(act_v === exp_v, req, $sformatf("clk/load/dout cycle %0d", k), act_v, exp_v);
        end
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic check_inputs(input string req);
        logic [31:0] got, exp_w;
        for (int w = 0; w < 4; w++) begin
            for (int i = 0; i < 32; i++)
                exp_w[i] = (used[w*32+i] ? feed[w*32+i] : 1'b0) ^ pol_v[w*32+i];
            rd(12 + w, got);
            chg_in: chk(got === exp_w, req, $sformatf("input word %0d", w), got, exp_w);
        end
    endtask

    task automatic quiet(input string req, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(ser_clk === 1'b0 && ser_load === 1'b0, req, "clk/load idle",
                {ser_clk, ser_load}, 0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset values on pins and registers
        chk({ser_clk, ser_load, ser_dout} === 3'b000, "R1", "pins after reset",
            {ser_clk, ser_load, ser_dout}, 0);
        rd(2, d); chk(d === 32'hFFFF_FFFF, "R1", "mask reset", d, 32'hFFFF_FFFF);
        rd(1, d); chk(d === 32'd4, "R1", "divider reset", d, 4);
        rd(0, d); chk(d === 32'h30, "R1", "control reset", d, 32'h30);

        // R2: readback and ignored writes to the input bank
        wr(1, 32'h1234); rd(1, d); chk(d === 32'h1234, "R2", "divider readback", d, 32'h1234);
        wr(2, 32'h0F0F_00FF); rd(2, d); chk(d === 32'h0F0F_00FF, "R2", "mask readback", d, 32'h0F0F_00FF);
        wr(0, 32'h20); rd(0, d); chk(d === 32'h20, "R2", "control readback", d, 32'h20);
        wr(5, 32'hA5A5_5A5A); rd(5, d); chk(d === 32'hA5A5_5A5A, "R2", "output word readback", d, 32'hA5A5_5A5A);
        wr(10, 32'h0000_C003); rd(10, d); chk(d === 32'h0000_C003, "R2", "polarity word readback", d, 32'h0000_C003);
        wr(10, 32'h0);
        wr(13, 32'hDEAD_BEEF); rd(13, d); chk(d === 32'h0, "R2", "input bank write ignored", d, 0);

        // R3 R4 R5 R6: full chain, four bits per port, fastest divider
        for (int g = 0; g < NG; g++) begin
            out_v[g] = (g % 3) == 0; pol_v[g] = 1'b0; feed[g] = ((g * 5 + 1) % 7) < 3;
        end
        load_pins();
        start(32'hFFFF_FFFF, 4, 1);
        run_frame("R3", -1, 0, 0);
        check_inputs("R6");

        // R7: sparse mask with two bits per port and inverted pins
        for (int g = 0; g < NG; g++) begin
            out_v[g] = g[1]; pol_v[g] = (g % 5) == 1; feed[g] = ((g * 3 + 2) % 5) < 2;
        end
        load_pins();
        start(32'h8000_0005, 2, 3);
        run_frame("R7", -1, 0, 0);
        check_inputs("R7");

        // R4: divider of zero acts as one, single bit per port
        start(32'h0000_0100, 1, 0);
        run_frame("R4", -1, 0, 0);
        check_inputs("R6");

        // R9: divider and mask written mid-frame apply only from the next frame
        start(32'h0000_0003, 3, 2);
        run_frame("R9", 5, 1, 32'd1);
        m_len = 1;
        run_frame("R9", 3, 2, 32'h0000_0010);
        m_mask = 32'h0000_0010;
        run_frame("R9", -1, 0, 0);

        // R8: all-zero mask stops new frames after the current one
        wr(2, 32'h0);
        repeat (60) @(negedge clk);
        quiet("R8", 30);

        // R8: clearing enable abandons a running frame
        start(32'hFFFF_FFFF, 4, 2);
        repeat (30) @(negedge clk);
        wr(0, 32'h30);
        quiet("R8", 20);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule